// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational integer execute stage of a small load-store processor core. It takes two 32-bit register operands, a 16-bit immediate, a 5-bit constant shift amount and a 5-bit operation code. It returns a 32-bit result and a signed-overflow flag. One adder serves add, subtract and both magnitude compares. One right-shifting barrel, with bit reversal at its input and output, serves all three shift kinds.

When `use_imm` is high, the second operand comes from an extender inside the block instead of `src_b`. The operation code selects the extension kind. The bitwise operations zero-extend the immediate. The add, subtract and compare operations sign-extend it.

The overflow flag reports a fault and does not alter the result. The consumer decides whether to cancel the register write. The block has no clock, no state and no handshake. The result follows the inputs within the same cycle.

Top module: `int_exec_unit`

## Requirements
- R1: The operation codes ADD (0), ADDU (1), SUB (2) and SUBU (3) produce `src_a + opB` and `src_a - opB` modulo 2^32, where opB is `src_b`, or the sign-extended immediate when `use_imm` is 1.
- R2: ADD (0) and SUB (2) raise `ovf` exactly when the true signed result does not fit in 32 bits. The wrapped result is still driven on `result`.
- R3: Every code other than 0 and 2, including ADDU (1) and SUBU (3), drives `ovf` low.
- R4: AND (4), OR (5), XOR (6) and NOR (7) compute the bitwise function of `src_a` and opB. NOR returns `~(src_a | opB)`.
- R5: SLT (8) compares `src_a < opB` as signed and SLTU (9) compares as unsigned. The result is 1 when the comparison holds and 0 otherwise, so bits 31:1 are always zero.
- R6: SLL (10), SRL (11) and SRA (12) shift `src_b` by `shamt`: left with zero fill, right with zero fill, and right with copies of `src_b[31]`. The shifts always take `src_b`, whatever the value of `use_imm`.
- R7: SLLV (13), SRLV (14) and SRAV (15) shift `src_b` in the same way as R6, by `src_a[4:0]`. Bits 31:5 of `src_a` have no effect.
- R8: Any shift by an amount of zero returns `src_b` unchanged.
- R9: With `use_imm` set, codes 0, 1, 2, 3, 8 and 9 use `{{16{imm16[15]}}, imm16}` as opB, and `src_b` has no effect. This includes the unsigned compare.
- R10: With `use_imm` set, codes 4, 5, 6 and 7 use `{16'h0, imm16}` as opB.
- R11: LUI (16) returns `{imm16, 16'h0000}`, whatever the values of `src_a`, `src_b` and `use_imm`.
- R12: The unused codes 17 through 31 return a result of 0 and drive `ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (encodings given in R1 to R12) |
| src_a | input | 32 | First register operand; low 5 bits give the amount for variable shifts |
| src_b | input | 32 | Second register operand; the operand that all shifts act on |
| imm16 | input | 16 | Immediate field |
| use_imm | input | 1 | Replace `src_b` with the extended immediate for non-shift operations |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of ADD or SUB |

## Verification
The block holds no state, so any internal error shows at `result` or `ovf` in the same cycle as the stimulus that exposes it. A wrong stage in the barrel shows only for shift amounts that have that bit of the amount set. For that reason every amount from 0 to 31 is swept for each shift kind.

A wrong carry or sign path in the shared adder shows first at the signed and unsigned compare boundaries and at the overflow edges. An extender that picks the wrong kind shows only when the immediate's bit 15 is set. The vectors therefore use immediates with that bit set and clear, paired with operands near the 32-bit limits.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int XLEN   = 32;
  localparam int IMMW   = 16;
  localparam int SHW    = $clog2(XLEN);
  localparam int OPW    = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,  OP_SLTU = 5'd9,
    OP_SLL  = 5'd10, OP_SRL  = 5'd11, OP_SRA  = 5'd12,
    OP_SLLV = 5'd13, OP_SRLV = 5'd14, OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } iex_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/iex_imm_ext.sv
module iex_imm_ext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm,
  input  logic             zero_ext,
  output logic [OUT_W-1:0] ext
);
  localparam int PAD = OUT_W - IN_W;

  always_comb begin
    ext = {{PAD{~zero_ext & imm[IN_W-1]}}, imm};
  end

  always_comb begin
    if (zero_ext) begin
      p_zext_upper_r10: assert (ext[OUT_W-1:IN_W] == '0)
        else $error("zero extension left upper bits set");
    end else begin
      p_sext_upper_r9: assert (ext[OUT_W-1:IN_W] == {PAD{imm[IN_W-1]}})
        else $error("sign extension upper bits wrong");
    end
  end
endmodule

// File: rtl/iex_adder.sv
module iex_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_s,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    ovf_s = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    lt_s  = sum[W-1] ^ ovf_s;
    lt_u  = ~wide[W];
  end

  always_comb begin
    if (ovf_s) begin
      p_ovf_sign_r2: assert (sum[W-1] != a[W-1])
        else $error("overflow flagged but sign did not flip");
    end
    if (sub && (a == b)) begin
      p_equal_not_less_r5: assert (!lt_s && !lt_u)
        else $error("equal operands compared as less");
    end
  end
endmodule

// File: rtl/iex_shifter.sv
module iex_shifter
  import iex_pkg::*;
#(
  parameter int W   = 32,
  parameter int AMW = $clog2(W)
) (
  input  logic [W-1:0]   data,
  input  logic [AMW-1:0] amt,
  input  shift_kind_e    kind,
  output logic [W-1:0]   out
);
  function automatic logic [W-1:0] bitrev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic         is_left;
  logic         fill;
  logic [W-1:0] stage [0:AMW];

  assign is_left  = (kind == SH_LEFT);
  assign fill     = (kind == SH_RARI) & data[W-1];
  assign stage[0] = is_left ? bitrev(data) : data;

  for (genvar k = 0; k < AMW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign out = is_left ? bitrev(stage[AMW]) : stage[AMW];

  always_comb begin
    if (amt == '0) begin
      p_zero_shift_passthru_r8: assert (out == data)
        else $error("zero-amount shift altered operand");
    end
    if (kind == SH_RARI) begin
      p_arith_fill_r6: assert (out[W-1] == data[W-1])
        else $error("arithmetic shift lost sign bit");
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
(
  input  logic [4:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [15:0] imm16,
  input  logic        use_imm,
  input  logic [4:0]  shamt,
  output logic [31:0] result,
  output logic        ovf
);
  iex_op_e          op;
  logic             zero_ext;
  logic             do_sub;
  logic [XLEN-1:0]  imm_x;
  logic [XLEN-1:0]  opb;
  logic [XLEN-1:0]  sum;
  logic             ovf_s, lt_s, lt_u;
  shift_kind_e      sh_kind;
  logic [SHW-1:0]   sh_amt;
  logic [XLEN-1:0]  sh_out;

  assign op = iex_op_e'(op_sel);

  always_comb begin
    zero_ext = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    do_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
    opb      = use_imm ? imm_x : src_b;
    unique case (op)
      OP_SLL, OP_SLLV: sh_kind = SH_LEFT;
      OP_SRA, OP_SRAV: sh_kind = SH_RARI;
      default:         sh_kind = SH_RLOG;
    endcase
    sh_amt = ((op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV)) ?
             src_a[SHW-1:0] : shamt;
  end

  iex_imm_ext #(.IN_W(IMMW), .OUT_W(XLEN)) u_ext (
    .imm(imm16), .zero_ext(zero_ext), .ext(imm_x)
  );

  iex_adder #(.W(XLEN)) u_add (
    .a(src_a), .b(opb), .sub(do_sub),
    .sum(sum), .ovf_s(ovf_s), .lt_s(lt_s), .lt_u(lt_u)
  );

  iex_shifter #(.W(XLEN), .AMW(SHW)) u_shf (
    .data(src_b), .amt(sh_amt), .kind(sh_kind), .out(sh_out)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_ADD, OP_SUB:   begin result = sum; ovf = ovf_s; end
      OP_ADDU, OP_SUBU: result = sum;
      OP_AND:  result = src_a & opb;
      OP_OR:   result = src_a | opb;
      OP_XOR:  result = src_a ^ opb;
      OP_NOR:  result = ~(src_a | opb);
      OP_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result = sh_out;
      OP_LUI:  result = {imm16, {(XLEN-IMMW){1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    if ((op_sel != 5'd0) && (op_sel != 5'd2)) begin
      p_no_overflow_r3: assert (!ovf) else $error("overflow on non-trapping op");
    end
    if ((op_sel == 5'd8) || (op_sel == 5'd9)) begin
      p_slt_boolean_r5: assert (result[XLEN-1:1] == '0) else $error("compare not 0/1");
    end
    if (op_sel == 5'd16) begin
      p_lui_low_clear_r11: assert (result[XLEN-IMMW-1:0] == '0) else $error("upper-imm low half set");
    end
    if (op_sel > 5'd16) begin
      p_unused_quiet_r12: assert (result == '0 && !ovf) else $error("unused code active");
    end
  end
endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic        use_imm;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  int_exec_unit dut_i (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm16(imm16),
    .use_imm(use_imm), .shamt(shamt), .result(result), .ovf(ovf)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic        ui;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] res;
    logic        ov;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 1'b0, 32'h5, 32'h7, 16'h0, 5'd0, 32'hC, 1'b0, 4'd1},                       // R1
    '{5'd0, 1'b0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b1, 4'd2},         // R2
    '{5'd1, 1'b0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b0, 4'd3},         // R3
    '{5'd2, 1'b0, 32'h3, 32'h5, 16'h0, 5'd0, 32'hFFFFFFFE, 1'b0, 4'd1},                // R1
    '{5'd2, 1'b0, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b1, 4'd2},         // R2
    '{5'd3, 1'b0, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, 4'd3},         // R3
    '{5'd0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, 32'hFFFFFFFE, 1'b0, 4'd2},  // R2 no ovf
    '{5'd4, 1'b0, 32'hF0F01234, 32'h0FF0FF00, 16'h0, 5'd0, 32'h00F01200, 1'b0, 4'd4},  // R4
    '{5'd5, 1'b0, 32'hF0F00000, 32'h0000000F, 16'h0, 5'd0, 32'hF0F0000F, 1'b0, 4'd4},  // R4
    '{5'd6, 1'b0, 32'hAAAA5555, 32'hFFFF0000, 16'h0, 5'd0, 32'h55555555, 1'b0, 4'd4},  // R4
    '{5'd7, 1'b0, 32'h0F0F0000, 32'h000000F0, 16'h0, 5'd0, 32'hF0F0FF0F, 1'b0, 4'd4},  // R4
    '{5'd8, 1'b0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h1, 1'b0, 4'd5},                // R5
    '{5'd9, 1'b0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0, 4'd5},                // R5
    '{5'd8, 1'b0, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, 1'b0, 4'd5},                       // R5
    '{5'd10, 1'b0, 32'h0, 32'h1, 16'h0, 5'd31, 32'h80000000, 1'b0, 4'd6},              // R6
    '{5'd11, 1'b0, 32'h0, 32'h80000000, 16'h0, 5'd4, 32'h08000000, 1'b0, 4'd6},        // R6
    '{5'd12, 1'b0, 32'h0, 32'h80000000, 16'h0, 5'd4, 32'hF8000000, 1'b0, 4'd6},        // R6
    '{5'd12, 1'b1, 32'h0, 32'h40000000, 16'hFFFF, 5'd30, 32'h1, 1'b0, 4'd6},           // R6
    '{5'd13, 1'b0, 32'h24, 32'hF, 16'h0, 5'd0, 32'hF0, 1'b0, 4'd7},                    // R7
    '{5'd15, 1'b0, 32'hFFFFFFE1, 32'h80000000, 16'h0, 5'd7, 32'hC0000000, 1'b0, 4'd7}, // R7
    '{5'd14, 1'b0, 32'h20, 32'hDEADBEEF, 16'h0, 5'd3, 32'hDEADBEEF, 1'b0, 4'd7},       // R7
    '{5'd10, 1'b0, 32'h0, 32'h12345678, 16'h0, 5'd0, 32'h12345678, 1'b0, 4'd8},        // R8
    '{5'd12, 1'b0, 32'h0, 32'h87654321, 16'h0, 5'd0, 32'h87654321, 1'b0, 4'd8},        // R8
    '{5'd0, 1'b1, 32'h10, 32'h999, 16'hFFFF, 5'd0, 32'hF, 1'b0, 4'd9},                 // R9
    '{5'd9, 1'b1, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b0, 4'd9},             // R9
    '{5'd8, 1'b1, 32'h0, 32'h7FFFFFFF, 16'h8000, 5'd0, 32'h0, 1'b0, 4'd9},             // R9
    '{5'd0, 1'b1, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b1, 4'd9},      // R9 with R2
    '{5'd2, 1'b1, 32'h5, 32'h123, 16'hFFFF, 5'd0, 32'h6, 1'b0, 4'd9},                  // R9
    '{5'd4, 1'b1, 32'h12345678, 32'hFFFFFFFF, 16'hFFFF, 5'd0, 32'h5678, 1'b0, 4'd10},  // R10
    '{5'd5, 1'b1, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h8000, 1'b0, 4'd10},                // R10
    '{5'd6, 1'b1, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd0, 32'hFFFF0000, 1'b0, 4'd10},     // R10
    '{5'd16, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 5'd9, 32'hABCD0000, 1'b0, 4'd11}, // R11
    '{5'd20, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd9, 32'h0, 1'b0, 4'd12}     // R12
  };

  task automatic apply(input logic [4:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [4:0] sh);
    @(posedge clk);
    op_sel = op; use_imm = ui; src_a = a; src_b = b; imm16 = im; shamt = sh;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic eo);
    n_chk++;
    if (result !== er || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s op=%0d result=%h ovf=%b expected result=%h ovf=%b",
               tag, op_sel, result, ovf, er, eo);
    end
  endtask

  initial begin
    op_sel = '0; use_imm = 1'b0; src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
    // Idle inputs: ADD of zeros (R1)
    @(negedge clk);
    check("R1 idle", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].ui, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].res, VECS[i].ov);
    end

    // R6 and R8: every constant amount for each shift kind
    for (int s = 0; s < 32; s++) begin
      apply(5'd10, 1'b0, 32'h0, 32'h80000001, 16'h0, 5'(s));
      check("R6 sll sweep", 32'h80000001 << s, 1'b0);
      apply(5'd11, 1'b0, 32'h0, 32'h80000001, 16'h0, 5'(s));
      check("R6 srl sweep", 32'h80000001 >> s, 1'b0);
      apply(5'd12, 1'b0, 32'h0, 32'h80000001, 16'h0, 5'(s));
      check("R6 sra sweep", 32'($signed(32'h80000001) >>> s), 1'b0);
    end

    // R7: upper bits of src_a ignored for variable shifts
    for (int s = 0; s < 32; s++) begin
      apply(5'd14, 1'b0, 32'hFFFFFFE0 | 32'(s), 32'hC3000000, 16'h0, 5'd0);
      check("R7 srlv sweep", 32'hC3000000 >> s, 1'b0);
    end

    // R1 and R3: modular add/sub over spread operands
    for (int k = 0; k < 16; k++) begin
      logic [31:0] a, b;
      a = 32'h9E3779B9 * 32'(k + 1);
      b = 32'h7F4A7C15 * 32'(k + 3);
      apply(5'd1, 1'b0, a, b, 16'h0, 5'd0);
      check("R1 addu sweep", a + b, 1'b0);
      apply(5'd3, 1'b0, a, b, 16'h0, 5'd0);
      check("R1 subu sweep", a - b, 1'b0);
      apply(5'd7, 1'b0, a, b, 16'h0, 5'd0);
      check("R4 nor sweep", ~(a | b), 1'b0);
    end

    // R12: all unused codes quiet
    for (int c = 17; c < 32; c++) begin
      apply(5'(c), 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'hFFFF, 5'd31);
      check("R12 unused code", 32'h0, 1'b0);
    end

    // R11: LUI independent of use_imm
    apply(5'd16, 1'b1, 32'h1234, 32'h5678, 16'h8001, 5'd0);
    check("R11 lui with use_imm", 32'h80010000, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired result=%h expected completion", result);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule